// File: doc/BRIEF.md
# Dual-CPU doorbell interrupt unit

This peripheral lets two processors ring each other through small doorbell words on a 32-bit APB slave port. Each processor owns a 4-bit status word. A write-one-to-set register raises bits in that word and a write-one-to-clear register lowers them. A processor usually rings its peer by setting bits in the peer's status word. The peer then takes the interrupt, reads its status and clears the bits it has handled.

Each processor has a level interrupt, and it stays high while that processor's status word is non-zero. The top of the 4 KB window holds a block of fixed, read-only identification bytes. Accesses to unmapped or inappropriate locations never stall and never report an error. Reads of those locations return zero and writes to them are dropped.

Top module: `cpu_doorbell`

## Requirements
- R1: Word offsets 0x000 (processor 0) and 0x010 (processor 1) read back that processor's status word in bits [3:0], with bits [31:4] zero.
- R2: A write to 0x004 (processor 0) or 0x014 (processor 1) ORs pwdata[3:0] into that processor's status. Bits [31:4] of the data are ignored and the other processor's status is unchanged.
- R3: A write to 0x008 (processor 0) or 0x018 (processor 1) clears every status bit of that processor for which pwdata[3:0] holds a 1. All other bits keep their value.
- R4: irq0 and irq1 are high exactly when the status of processor 0 or 1, respectively, is non-zero. Each output changes on the clock edge after the write edge that altered the status.
- R5: Reading a set or clear register returns zero. Writing a status register or an identification register changes no state.
- R6: Reading any unmapped word returns zero and writing one changes no state. pready is always 1 and pslverr is always 0.
- R7: Words 0xFD0 to 0xFFC read, in ascending address order, the bytes 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with zero above.
- R8: An active-low presetn clears both status words and drives both interrupts low.
- R9: Only paddr[11:2] is decoded. paddr[1:0] has no effect on reads or writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0, no error responses |
| irq0 | output | 1 | Doorbell interrupt to processor 0 |
| irq1 | output | 1 | Doorbell interrupt to processor 1 |

## Verification
The bus carries one access per cycle, so the only overlap is between a status update and the registered interrupt lagging behind it. A set or clear lands on one edge while irqN still shows the old level until the next edge. The bench provokes this by emptying or filling a status word and then sampling the interrupt twice: straight after the write edge, where the old level is expected, and one edge later, where the new level is expected. A following read of the status word confirms the value that the interrupt has just caught up with.

// File: rtl/cpu_doorbell.sv
module cpu_doorbell #(
  parameter int NBITS = 4,
  parameter int AW    = 12
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          irq0,
  output logic          irq1
);
  localparam int WA = AW - 2;
  localparam logic [WA-1:0] W_ST0 = WA'(0);
  localparam logic [WA-1:0] W_SET0 = WA'(1);
  localparam logic [WA-1:0] W_CLR0 = WA'(2);
  localparam logic [WA-1:0] W_ST1 = WA'(4);
  localparam logic [WA-1:0] W_SET1 = WA'(5);
  localparam logic [WA-1:0] W_CLR1 = WA'(6);
  localparam logic [WA-1:0] W_ID = WA'((1 << WA) - 12);

  logic [WA-1:0]    widx;
  logic             wr, rd;
  logic [NBITS-1:0] stat0, stat1;
  logic [NBITS-1:0] wbits;
  logic [WA-1:0]    idoff;

  assign widx    = paddr[AW-1:2];
  assign wr      = psel & penable & pwrite;
  assign rd      = psel & ~pwrite;
  assign wbits   = pwdata[NBITS-1:0];
  assign idoff   = widx - W_ID;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h56;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h0B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      stat0 <= '0;
      stat1 <= '0;
    end else if (wr) begin
      if (widx == W_SET0) stat0 <= stat0 | wbits;
      if (widx == W_CLR0) stat0 <= stat0 & ~wbits;
      if (widx == W_SET1) stat1 <= stat1 | wbits;
      if (widx == W_CLR1) stat1 <= stat1 & ~wbits;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      irq0 <= |stat0;
      irq1 <= |stat1;
    end
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      if (widx == W_ST0)      prdata[NBITS-1:0] = stat0;
      else if (widx == W_ST1) prdata[NBITS-1:0] = stat1;
      else if (widx >= W_ID)  prdata[7:0] = id_byte(idoff[3:0]);
    end
  end

  p_set_nonzero_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && widx == W_SET0 && wbits != '0) |=> (stat0 != '0));

  p_irq_after_set_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && widx == W_SET1 && wbits != '0) |=> ##1 irq1);

  p_full_clear_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && widx == W_CLR0 && (&wbits)) |=> ##1 !irq0);

  p_ro_write_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && (widx == W_ST0 || widx == W_ST1 || widx >= W_ID)) |=> ($stable(stat0) && $stable(stat1)));

  p_wo_read_zero_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && (widx == W_SET0 || widx == W_CLR1)) |-> (prdata == 32'h0));

  p_status_upper_zero_r1: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && widx == W_ST1) |-> (prdata[31:NBITS] == '0));
endmodule

// File: tb/cpu_doorbell_tb.sv
module cpu_doorbell_tb;
  localparam int CLK_PERIOD = 10;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq0, irq1;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] m0, m1;
  logic [31:0] got;

  cpu_doorbell u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq0(irq0), .irq1(irq1)
  );

  always #(CLK_PERIOD/2) pclk = ~pclk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #1;
    d = prdata;
    check("R6 pready", {31'b0, pready}, 32'h1);
    check("R6 pslverr", {31'b0, pslverr}, 32'h0);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  function automatic logic [31:0] exp_id(input int k);
    case (k)
      0: exp_id = 32'h04;  4: exp_id = 32'h56;  5: exp_id = 32'hB8;
      6: exp_id = 32'h0B;  8: exp_id = 32'h0D;  9: exp_id = 32'hF0;
      10: exp_id = 32'h05; 11: exp_id = 32'hB1;
      default: exp_id = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int w, input logic [3:0] s0, input logic [3:0] s1);
    if (w == 0) exp_rd = {28'b0, s0};
    else if (w == 4) exp_rd = {28'b0, s1};
    else if (w >= 1012) exp_rd = exp_id(w - 1012);
    else exp_rd = 32'h0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    check("R8 irq0 in reset", {31'b0, irq0}, 32'h0);
    check("R8 irq1 in reset", {31'b0, irq1}, 32'h0);
    repeat (3) @(negedge pclk);
    presetn = 1;
    apb_read(12'h000, got); check("R8 status0 after reset", got, 32'h0);
    apb_read(12'h010, got); check("R8 status1 after reset", got, 32'h0);

    // R2 R3 R4 sweep of start state and write data, both processors
    for (int cpu = 0; cpu < 2; cpu++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [11:0] base;
          logic [3:0] mdl;
          logic irq;
          base = (cpu == 0) ? 12'h000 : 12'h010;
          apb_write(base + 12'h8, 32'hFFFF_FFFF);
          apb_write(base + 12'h4, {28'hABCDEF1, a[3:0]});
          mdl = a[3:0];
          apb_read(base, got); check("R2 set from empty", got, {28'b0, mdl});
          apb_read(base ^ 12'h010, got); check("R2 other cpu untouched", got, 32'h0);
          apb_write(base + 12'h4, {28'h5, b[3:0]});
          mdl = mdl | b[3:0];
          apb_read(base, got); check("R2 set OR", got, {28'b0, mdl});
          irq = (cpu == 0) ? irq0 : irq1;
          check("R4 irq level after set", {31'b0, irq}, {31'b0, mdl != 0});
          apb_write(base + 12'h8, {28'hFFFFFFF, b[3:0]});
          irq = (cpu == 0) ? irq0 : irq1;
          check("R4 irq lags one edge", {31'b0, irq}, {31'b0, mdl != 0});
          mdl = mdl & ~b[3:0];
          @(negedge pclk);
          irq = (cpu == 0) ? irq0 : irq1;
          check("R4 irq after clear", {31'b0, irq}, {31'b0, mdl != 0});
          apb_read(base, got); check("R3 clear", got, {28'b0, mdl});
        end
      end
      apb_write((cpu == 0) ? 12'h008 : 12'h018, 32'hF);
    end

    // R9 byte offset ignored
    apb_write(12'h005, 32'h3);
    apb_write(12'h017, 32'hC);
    apb_read(12'h002, got); check("R9 set via offset 1", got, 32'h3);
    apb_read(12'h013, got); check("R9 set via offset 3", got, 32'hC);
    apb_write(12'h00A, 32'h1);
    apb_read(12'h001, got); check("R9 clear via offset 2", got, 32'h2);
    apb_read(12'hFE3, got); check("R9 id read offset 3", got, 32'h56);
    apb_write(12'h008, 32'hF);
    apb_write(12'h018, 32'hF);

    // R1 R5 R6 R7 read sweep of whole window
    apb_write(12'h004, 32'h5);
    apb_write(12'h014, 32'hA);
    m0 = 4'h5; m1 = 4'hA;
    for (int w = 0; w < 1024; w++) begin
      apb_read(12'(w * 4), got);
      if (w == 0 || w == 4) check("R1 status read", got, exp_rd(w, m0, m1));
      else if (w == 1 || w == 2 || w == 5 || w == 6) check("R5 write-only reads zero", got, 32'h0);
      else if (w >= 1012) check("R7 id value", got, exp_rd(w, m0, m1));
      else check("R6 unmapped reads zero", got, 32'h0);
    end

    // R5 R6 writes to read-only and unmapped words change nothing
    for (int w = 0; w < 1024; w++) begin
      if (!(w == 1 || w == 2 || w == 5 || w == 6)) apb_write(12'(w * 4), 32'hFFFF_FFFF);
    end
    apb_read(12'h000, got); check("R5 R6 status0 unchanged", got, 32'h5);
    apb_read(12'h010, got); check("R5 R6 status1 unchanged", got, 32'hA);
    apb_read(12'hFF0, got); check("R5 id unchanged", got, 32'h0D);
    check("R4 irq0 held", {31'b0, irq0}, 32'h1);
    check("R4 irq1 held", {31'b0, irq1}, 32'h1);

    // R8 reset mid-run
    @(negedge pclk); presetn = 0;
    #1;
    check("R8 irq0 cleared", {31'b0, irq0}, 32'h0);
    check("R8 irq1 cleared", {31'b0, irq1}, 32'h0);
    @(negedge pclk); presetn = 1;
    apb_read(12'h000, got); check("R8 status0 cleared", got, 32'h0);
    apb_read(12'h010, got); check("R8 status1 cleared", got, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule